// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces a pulse-width modulated output from a period count and a high-time width. A free-running up-counter advances once for each cycle in which the external tick enable is high. The output is high while the counter is below the active width. Software writes the period count and the width into holding registers through a small register write port. These values move into the active registers only when a period completes, so a period already under way is never disturbed.

A force-reload bit in the control register overrides this wait. It restarts the counter at zero in the same clock edge and loads the held settings at once. The bit never stays set: it always reads back as zero. A one-cycle period-complete strobe marks every counter wrap. The strobe also sets a sticky status flag, which software clears by writing a one to it. The control register also holds an enable bit and an output-inversion bit. The inversion bit is applied directly and does not wait for a period boundary.

Register addresses are: 0 = period count, 1 = width, 2 = control (bit 0 enable, bit 1 force reload, bit 2 invert), 3 = status (bit 0 sticky period flag, write 1 to clear). All reads are combinational from `rdAddr`.

Top module: `pwm_shadow`

## Requirements
- R1: After reset, `pwmOut` and `periodDone` are 0, and every register at addresses 0 to 3 reads 0.
- R2: While enabled, the counter steps by one on each cycle with `tickEn` high. It runs from 0 to count-1 and then returns to 0. With invert clear, `pwmOut` is 1 exactly while the counter is below the active width. A count of 0 or 1 makes every tick a wrap.
- R3: An active width of 0 keeps `pwmOut` low for the whole period. An active width at or above the count keeps it high.
- R4: Count or width values written to addresses 0 or 1 reach the active registers only at the edge where the counter wraps. Until then, the output follows the previous settings.
- R5: Writing control with bit 1 set resets the counter to 0 and loads the held count and width at that same edge, whether or not `tickEn` is high. This edge does not produce a period-complete strobe.
- R6: Bit 1 of the control register always reads 0.
- R7: `periodDone` is high for one cycle, in the cycle that follows each enabled tick that wraps the counter.
- R8: The sticky flag (address 3, bit 0) is set at the edge after `periodDone` is high. It stays set until a write of 1 to address 3 bit 0. If a set and a clear happen in the same cycle, the set wins.
- R9: With enable clear, `pwmOut` is 0, the counter is held at 0, and the active registers follow the held values.
- R10: The invert bit (control bit 2) inverts `pwmOut` from the cycle after it is written, without waiting for a period boundary.
- R11: An enabled cycle with `tickEn` low and no force reload leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled count enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | CNT_W | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | CNT_W | Register read data |
| pwmOut | output | 1 | PWM output |
| periodDone | output | 1 | One-cycle period-complete strobe |

## Verification
The bench builds the block with the default 8-bit counter. It keeps the random period counts between 0 and 12 and the widths between 0 and 14, so wraps, reloads held in the shadow registers, zero widths and widths above the count all occur many times in a few thousand cycles. Random writes that land in the middle of a period, together with random gaps in `tickEn`, exercise the deferred reload against the forced one.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_WIDTH  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  // control bit positions
  localparam int CTRL_EN    = 0;
  localparam int CTRL_FORCE = 1;
  localparam int CTRL_INV   = 2;

  typedef struct packed {
    logic enable;
    logic invert;
    logic forceLoad;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  input  logic             periodDone,
  output pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] cntShadow,
  output logic [CNT_W-1:0] widShadow,
  output logic [CNT_W-1:0] rdData,
  output logic             stickyDone
);
  logic enReg, invReg;
  logic wrCtrl, wrStat;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrStat = wrEn && (wrAddr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntShadow  <= '0;
      widShadow  <= '0;
      enReg      <= 1'b0;
      invReg     <= 1'b0;
      stickyDone <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_COUNT) cntShadow <= wrData;
      if (wrEn && wrAddr == ADDR_WIDTH) widShadow <= wrData;
      if (wrCtrl) begin
        enReg  <= wrData[CTRL_EN];
        invReg <= wrData[CTRL_INV];
      end
      if (periodDone)              stickyDone <= 1'b1;
      else if (wrStat && wrData[0]) stickyDone <= 1'b0;
    end
  end

  // force reload acts at the write edge and is never stored
  assign strobe.enable    = enReg;
  assign strobe.invert    = invReg;
  assign strobe.forceLoad = wrCtrl && wrData[CTRL_FORCE];

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_COUNT:  rdData = cntShadow;
      ADDR_WIDTH:  rdData = widShadow;
      ADDR_CTRL: begin
        rdData[CTRL_EN]  = enReg;
        rdData[CTRL_INV] = invReg;
      end
      default:     rdData[0] = stickyDone;
    endcase
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntShadow,
  input  logic [CNT_W-1:0] widShadow,
  output logic [CNT_W-1:0] cnt,
  output logic             pwmOut,
  output logic             periodDone
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntAct, widAct, lastCnt;
  logic             wrap;

  assign lastCnt = (cntAct == '0) ? '0 : cntAct - ONE;
  assign wrap    = (cnt >= lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      cntAct     <= '0;
      widAct     <= '0;
      periodDone <= 1'b0;
    end else begin
      periodDone <= 1'b0;
      if (strobe.forceLoad || !strobe.enable) begin
        cnt    <= '0;
        cntAct <= cntShadow;
        widAct <= widShadow;
      end else if (tickEn) begin
        if (wrap) begin
          cnt        <= '0;
          cntAct     <= cntShadow;
          widAct     <= widShadow;
          periodDone <= 1'b1;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  assign pwmOut = strobe.enable && ((cnt < widAct) ^ strobe.invert);
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             pwmOut,
  output logic             periodDone
);
  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] cntShadow, widShadow, cnt;
  logic             stickyDone;

  pwm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .periodDone(periodDone), .strobe(strobe),
    .cntShadow(cntShadow), .widShadow(widShadow), .rdData(rdData),
    .stickyDone(stickyDone)
  );

  pwm_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .cntShadow(cntShadow), .widShadow(widShadow), .cnt(cnt),
    .pwmOut(pwmOut), .periodDone(periodDone)
  );
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic [1:0]       rdAddr,
  input logic [CNT_W-1:0] rdData,
  input logic             pwmOut,
  input logic             periodDone,
  input logic             enable,
  input logic             forceLoad,
  input logic             sticky,
  input logic [CNT_W-1:0] cnt
);
  // R9
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !pwmOut);

  // R7
  done_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |-> $past(tickEn));

  // R6
  force_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd2) |-> !rdData[1]);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodDone |=> sticky);

  // R11
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tickEn && !forceLoad) |=> $stable(cnt));
endmodule

bind pwm_shadow pwm_shadow_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .rdAddr(rdAddr), .rdData(rdData),
  .pwmOut(pwmOut), .periodDone(periodDone), .enable(strobe.enable),
  .forceLoad(strobe.forceLoad), .sticky(stickyDone), .cnt(cnt)
);

// File: tb/tb_pwm_shadow.sv
module tb_pwm_shadow;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickEn = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [1:0]       rdAddr = '0;
  logic [CNT_W-1:0] rdData;
  logic             pwmOut, periodDone;

  int checks = 0;
  int errors = 0;
  string tag = "R2";
  bit done = 1'b0;

  // bench model state
  logic [CNT_W-1:0] mCntSh, mWidSh, mCnt, mCntAct, mWidAct;
  logic mEn, mInv, mSticky, mDone;

  always #2.5 clk = ~clk;

  pwm_shadow #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut),
    .periodDone(periodDone)
  );

  task automatic check(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expPwm();
    return mEn && ((mCnt < mWidAct) ^ mInv);
  endfunction

  function automatic logic [CNT_W-1:0] expRd(logic [1:0] a);
    case (a)
      2'd0: return mCntSh;
      2'd1: return mWidSh;
      2'd2: return {{(CNT_W-3){1'b0}}, mInv, 1'b0, mEn};
      default: return {{(CNT_W-1){1'b0}}, mSticky};
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lastOf(logic [CNT_W-1:0] c);
    return (c == 0) ? '0 : c - 1'b1;
  endfunction

  task automatic modelReset();
    mCntSh = '0; mWidSh = '0; mCnt = '0; mCntAct = '0; mWidAct = '0;
    mEn = 0; mInv = 0; mSticky = 0; mDone = 0;
  endtask

  task automatic modelEdge();
    logic force_, nDone;
    force_ = wrEn && wrAddr == 2'd2 && wrData[1];
    nDone = 1'b0;
    if (force_ || !mEn) begin
      mCnt = '0; mCntAct = mCntSh; mWidAct = mWidSh;
    end else if (tickEn) begin
      if (mCnt >= lastOf(mCntAct)) begin
        mCnt = '0; mCntAct = mCntSh; mWidAct = mWidSh; nDone = 1'b1;
      end else mCnt = mCnt + 1'b1;
    end
    if (mDone) mSticky = 1'b1;
    else if (wrEn && wrAddr == 2'd3 && wrData[0]) mSticky = 1'b0;
    mDone = nDone;
    if (wrEn && wrAddr == 2'd0) mCntSh = wrData;
    if (wrEn && wrAddr == 2'd1) mWidSh = wrData;
    if (wrEn && wrAddr == 2'd2) begin mEn = wrData[0]; mInv = wrData[2]; end
  endtask

  // one clock: inputs already driven; check outputs afterwards
  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag, CNT_W'(pwmOut), CNT_W'(expPwm()));
    check("R7", CNT_W'(periodDone), CNT_W'(mDone));
    check(rdAddr == 2'd2 ? "R6" : (rdAddr == 2'd3 ? "R8" : "R4"),
          rdData, expRd(rdAddr));
    wrEn = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, int d);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    cycle();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tickEn = 1'b1; cycle(); end
    tickEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", CNT_W'(pwmOut), '0);
    check("R1", CNT_W'(periodDone), '0);
    for (int a = 0; a < 4; a++) begin
      rdAddr = 2'(a); #0.1;
      check("R1", rdData, '0);
    end
    rdAddr = 2'd3;

    // R9 disabled: held low with settings written
    tag = "R9";
    wr(2'd0, 5); wr(2'd1, 2); ticks(4);
    // R2 basic waveform
    tag = "R2";
    wr(2'd2, 1); ticks(12);
    // R11 gaps in tick
    tag = "R11";
    for (int i = 0; i < 10; i++) begin tickEn = i[0]; cycle(); end
    // R4 mid-period shadow update
    tag = "R4";
    ticks(1); wr(2'd0, 7); wr(2'd1, 4); ticks(14);
    // R5 force reload mid period, no tick
    tag = "R5";
    ticks(2); wr(2'd1, 1); wr(2'd2, 3); cycle(); ticks(9);
    // R3 width zero and width above count
    tag = "R3";
    wr(2'd1, 0); ticks(16);
    wr(2'd1, 9); ticks(16);
    wr(2'd1, 7); ticks(10);
    // R10 invert applied at once
    tag = "R10";
    wr(2'd1, 3); ticks(3); wr(2'd2, 5); ticks(6); wr(2'd2, 1); ticks(3);
    // R8 clear sticky, then set-wins case
    tag = "R8";
    rdAddr = 2'd3; wr(2'd3, 1); ticks(2);
    wr(2'd0, 1); ticks(2);
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd3; wrData = 1; cycle();
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd3; wrData = 1; cycle();
    tickEn = 1'b0; cycle();
    // R9 disable mid period
    tag = "R9";
    wr(2'd0, 6); ticks(3); wr(2'd2, 0); ticks(5);

    // random phase
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r;
      tickEn = ($urandom % 2) == 0;
      rdAddr = 2'($urandom % 4);
      r = $urandom % 100;
      if (r < 20) begin
        wrEn = 1'b1;
        wrAddr = 2'($urandom % 4);
        case (wrAddr)
          2'd0: wrData = CNT_W'($urandom % 13);
          2'd1: wrData = CNT_W'($urandom % 15);
          2'd2: wrData = CNT_W'({($urandom % 8) == 0, ($urandom % 6) == 0,
                                  ($urandom % 10) != 0});
          default: wrData = CNT_W'($urandom % 2);
        endcase
      end
      cycle();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule